// File: doc/BRIEF.md
# PLL Relock Sequencer

This block retunes a single PLL to a requested frequency. A requester hands it a rate in MHz over a valid/ready request channel. The sequencer walks a constant table of supported operating points, one entry per clock. It keeps the entry whose rate lies nearest the request. It then programs the PLL control register through a simple register-write port and lets the loop settle for a fixed interval derived from the system clock frequency. At the end of that interval it samples the lock and error status inputs and reports the outcome with a one-cycle completion pulse and a two-bit result code.

When `core_mode` is high at the time a request is taken, the PLL is treated as feeding a processor core. The sequencer then also steers a core-interface clock divider. The divider is raised to divide-by-2 ahead of any move above the threshold frequency. It is brought back to divide-by-1 only once a move to a rate at or below the threshold has relocked cleanly.

Back-pressure rules on the request channel: a request transfers on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. It is low from the cycle after a transfer up to and including the cycle of the completion pulse. A requester that raises `req_valid` while `req_ready` is low is not served; if it keeps `req_valid` high, the request is taken once `req_ready` rises again.

Top module: `pllrc_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0 and `reg_wr_en` is 0.
- R2: The chosen operating point is the table entry whose rate has the smallest absolute difference from `req_rate` (MHz). On equal distance the lower-rate, earlier entry wins. The table spans 100 MHz to 1600 MHz, e.g. 125, 400, 500, 800, 1500 and 1600 MHz are entries; any request below 100 gives 100 and any request above 1600 gives 1600.
- R3: The control write (`reg_wr_sel`=0) carries the output-divider code in bits 3:2, the input-divider code in bits 8:4, the feedback-divider code in bits 15:9 and the band code in bits 23:20. Bits 1:0 (power-down, bypass) and all other bits are 0. Examples: 800 MHz gives codes input 0, feedback 23, output 1; 1600 MHz gives input 1, feedback 47, output 0; 1500 MHz gives 1/44/0; 400 MHz gives 1/47/2; 500 MHz gives 0/14/1; 125 MHz gives 0/14/3; 100 MHz gives 0/11/3.
- R4: `done` rises exactly CLK_HZ/1e6*LOCK_US + 1 cycles after the cycle of the control write. `pll_lock` and `pll_err` are sampled in the last cycle before that.
- R5: In core mode with a chosen rate above THRESH_MHZ (500), a divider write (`reg_wr_sel`=1, data 1) occurs in the cycle directly before the control write.
- R6: In core mode with a chosen rate at or below THRESH_MHZ, a divider write with data 0 occurs in the same cycle as `done`, and only when the result is ok. No other divider write occurs for such a request.
- R7: `result` during `done` is 1 (timeout) if the lock input was low, else 2 (error) if the error input was high, else 0 (ok). A timeout takes precedence over an error.
- R8: `done` is a single-cycle pulse, issued exactly once per accepted request.
- R9: While busy, `req_ready` is 0 and a request presented and withdrawn during that time causes no write and no completion.
- R10: With `core_mode` low, no divider write (`reg_wr_sel`=1) is ever issued; only the control write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_mode | input | 1 | Request targets a core PLL; sampled with the request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_rate | input | RATE_W | Requested rate in MHz |
| reg_wr_en | output | 1 | Register write strobe, one cycle |
| reg_wr_sel | output | 1 | Write target: 0 PLL control, 1 interface divider |
| reg_wr_data | output | 32 | Write data |
| pll_lock | input | 1 | PLL lock status |
| pll_err | input | 1 | PLL error status |
| done | output | 1 | Completion pulse |
| result | output | 2 | Outcome: 0 ok, 1 timeout, 2 error |

## Verification
The completion pulse and the divider-down write share a cycle: a core-mode request at or below the threshold that relocks cleanly must show both at one sampling point. The bench provokes this with 450 MHz and 500 MHz requests and compares the logged cycle of the divider write with the cycle of `done`. It also drives failing relocks at a low rate to judge that the pulse then comes alone. The other overlap, a fresh request arriving while a relock is in flight, is provoked by raising `req_valid` mid-wait. It is judged by the absence of any extra write or completion afterwards.

// File: rtl/pllrc_pkg.sv
package pllrc_pkg;

  localparam int MHZ_W     = 11;
  localparam int ROM_IDX_W = 5;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_TIMEOUT = 2'd1,
    RES_ERROR   = 2'd2
  } pll_result_e;

  typedef struct packed {
    logic [MHZ_W-1:0] mhz;
    logic [4:0]       idiv;
    logic [6:0]       fbdiv;
    logic [1:0]       odiv;
    logic [3:0]       band;
  } pll_entry_t;

  function automatic pll_entry_t mk(input logic [MHZ_W-1:0] m, input logic [4:0] i,
                                    input logic [6:0] f, input logic [1:0] o);
    pll_entry_t e;
    e.mhz   = m;
    e.idiv  = i;
    e.fbdiv = f;
    e.odiv  = o;
    e.band  = 4'd0;
    return e;
  endfunction

  // Operating points in ascending rate; a zero rate ends the list.
  function automatic pll_entry_t entry_at(input logic [ROM_IDX_W-1:0] idx);
    case (idx)
      5'd0:    return mk(11'd100,  5'd0, 7'd11, 2'd3);
      5'd1:    return mk(11'd125,  5'd0, 7'd14, 2'd3);
      5'd2:    return mk(11'd133,  5'd0, 7'd15, 2'd3);
      5'd3:    return mk(11'd150,  5'd0, 7'd17, 2'd3);
      5'd4:    return mk(11'd200,  5'd1, 7'd47, 2'd3);
      5'd5:    return mk(11'd233,  5'd1, 7'd27, 2'd2);
      5'd6:    return mk(11'd300,  5'd1, 7'd35, 2'd2);
      5'd7:    return mk(11'd333,  5'd1, 7'd39, 2'd2);
      5'd8:    return mk(11'd400,  5'd1, 7'd47, 2'd2);
      5'd9:    return mk(11'd500,  5'd0, 7'd14, 2'd1);
      5'd10:   return mk(11'd600,  5'd0, 7'd17, 2'd1);
      5'd11:   return mk(11'd700,  5'd0, 7'd20, 2'd1);
      5'd12:   return mk(11'd800,  5'd0, 7'd23, 2'd1);
      5'd13:   return mk(11'd900,  5'd1, 7'd26, 2'd0);
      5'd14:   return mk(11'd1000, 5'd1, 7'd29, 2'd0);
      5'd15:   return mk(11'd1100, 5'd1, 7'd32, 2'd0);
      5'd16:   return mk(11'd1200, 5'd1, 7'd35, 2'd0);
      5'd17:   return mk(11'd1300, 5'd1, 7'd38, 2'd0);
      5'd18:   return mk(11'd1400, 5'd1, 7'd41, 2'd0);
      5'd19:   return mk(11'd1500, 5'd1, 7'd44, 2'd0);
      5'd20:   return mk(11'd1600, 5'd1, 7'd47, 2'd0);
      default: return mk(11'd0,    5'd0, 7'd0,  2'd0);
    endcase
  endfunction

  function automatic logic [31:0] pack_ctrl(input pll_entry_t e);
    logic [31:0] w;
    w        = '0;
    w[3:2]   = e.odiv;
    w[8:4]   = e.idiv;
    w[15:9]  = e.fbdiv;
    w[23:20] = e.band;
    return w;
  endfunction

endpackage

// File: rtl/pllrc_nearest.sv
module pllrc_nearest
  import pllrc_pkg::*;
#(
  parameter int RATE_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [RATE_W-1:0]    target,
  output logic                 fin,
  output logic [ROM_IDX_W-1:0] best_idx
);

  localparam int DIFF_W = RATE_W + 1;

  logic                 running;
  logic [ROM_IDX_W-1:0] idx;
  logic [DIFF_W-1:0]    best_diff;
  logic [DIFF_W-1:0]    diff;
  logic [DIFF_W-1:0]    ext_rate;
  logic [DIFF_W-1:0]    ext_tgt;
  pll_entry_t           cur;

  assign cur      = entry_at(idx);
  assign ext_rate = {{(DIFF_W-MHZ_W){1'b0}}, cur.mhz};
  assign ext_tgt  = {1'b0, target};
  assign diff     = (ext_tgt >= ext_rate) ? (ext_tgt - ext_rate) : (ext_rate - ext_tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      idx       <= '0;
      best_diff <= '1;
      best_idx  <= '0;
      fin       <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        running   <= 1'b1;
        idx       <= '0;
        best_diff <= '1;
        best_idx  <= '0;
      end else if (running) begin
        if (cur.mhz == '0) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end else begin
          if (diff < best_diff) begin   // strict: ties keep the earlier entry
            best_diff <= diff;
            best_idx  <= idx;
          end
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assert_best_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> (best_diff <= $past(best_diff)));

endmodule

// File: rtl/pllrc_relock_timer.sv
module pllrc_relock_timer #(
  parameter int CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);

  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic             running;
  logic [CNT_W-1:0] cnt;

  assign expire = running && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (running) begin
      if (expire) begin
        running <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_wait_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= LAST));

endmodule

// File: rtl/pllrc_ctrl.sv
module pllrc_ctrl
  import pllrc_pkg::*;
#(
  parameter int CLK_HZ     = 250_000_000,
  parameter int LOCK_US    = 100,
  parameter int THRESH_MHZ = 500,
  parameter int RATE_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RATE_W-1:0] req_rate,
  output logic              reg_wr_en,
  output logic              reg_wr_sel,
  output logic [31:0]       reg_wr_data,
  input  logic              pll_lock,
  input  logic              pll_err,
  output logic              done,
  output logic [1:0]        result
);

  localparam int WAIT_CYCLES = (CLK_HZ / 1_000_000) * LOCK_US;
  localparam logic [MHZ_W-1:0] THRESH_L = MHZ_W'(THRESH_MHZ);
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_DIV  = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_RAISE, ST_PROG, ST_WAIT, ST_FIN
  } state_e;

  state_e               state;
  logic [RATE_W-1:0]    tgt_q;
  logic                 core_q;
  logic                 lock_q;
  logic                 err_q;
  logic                 scan_start;
  logic                 scan_fin;
  logic [ROM_IDX_W-1:0] best_idx;
  logic                 timer_start;
  logic                 timer_expire;
  logic                 above;
  pll_entry_t           sel_entry;
  pll_result_e          res_c;

  assign req_ready   = (state == ST_IDLE);
  assign scan_start  = req_ready && req_valid;
  assign timer_start = (state == ST_PROG);
  assign sel_entry   = entry_at(best_idx);
  assign above       = sel_entry.mhz > THRESH_L;

  pllrc_nearest #(.RATE_W(RATE_W)) u_nearest (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (scan_start),
    .target   (tgt_q),
    .fin      (scan_fin),
    .best_idx (best_idx)
  );

  pllrc_relock_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (timer_start),
    .expire (timer_expire)
  );

  // tgt_q is captured on the accept edge; the scanner starts on the same edge
  // and reads it from the following cycle on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tgt_q  <= '0;
      core_q <= 1'b0;
      lock_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          tgt_q  <= req_rate;
          core_q <= core_mode;
          state  <= ST_SCAN;
        end
        ST_SCAN:  if (scan_fin) state <= ST_RAISE;
        ST_RAISE: state <= ST_PROG;
        ST_PROG:  state <= ST_WAIT;
        ST_WAIT: if (timer_expire) begin
          lock_q <= pll_lock;
          err_q  <= pll_err;
          state  <= ST_FIN;
        end
        ST_FIN:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (!lock_q)     res_c = RES_TIMEOUT;
    else if (err_q)  res_c = RES_ERROR;
    else             res_c = RES_OK;
  end

  assign done   = (state == ST_FIN);
  assign result = done ? res_c : RES_OK;

  always_comb begin
    reg_wr_en   = 1'b0;
    reg_wr_sel  = SEL_CTRL;
    reg_wr_data = '0;
    case (state)
      ST_RAISE: if (core_q && above) begin
        reg_wr_en   = 1'b1;
        reg_wr_sel  = SEL_DIV;
        reg_wr_data = 32'd1;
      end
      ST_PROG: begin
        reg_wr_en   = 1'b1;
        reg_wr_sel  = SEL_CTRL;
        reg_wr_data = pack_ctrl(sel_entry);
      end
      ST_FIN: if (res_c == RES_OK && core_q && !above) begin
        reg_wr_en   = 1'b1;
        reg_wr_sel  = SEL_DIV;
        reg_wr_data = 32'd0;
      end
      default: ;
    endcase
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_up_before_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_sel && reg_wr_data == 32'd1) |=> (reg_wr_en && !reg_wr_sel));

  assert_no_write_on_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result != RES_OK) |-> !reg_wr_en);

  assert_ctrl_guard_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_wr_sel) |-> (reg_wr_data[1:0] == 2'b00));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!reg_wr_en && !done));

  assert_noncore_no_div_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_sel) |-> core_q);

endmodule

// File: tb/pllrc_ctrl_tb_top.sv
`timescale 1ns/1ps
module pllrc_ctrl_tb_top;

  localparam int CLK_HZ   = 10_000_000;
  localparam int LOCK_US  = 100;
  localparam int W        = (CLK_HZ / 1_000_000) * LOCK_US;
  localparam int LOCK_DLY = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_rate = '0;
  logic        reg_wr_en;
  logic        reg_wr_sel;
  logic [31:0] reg_wr_data;
  logic        pll_lock = 1'b1;
  logic        pll_err;
  logic        done;
  logic [1:0]  result;

  bit lock_never = 1'b0;
  bit err_mode   = 1'b0;
  assign pll_err = err_mode;

  always #2 clk = ~clk;  // 250 MHz

  pllrc_ctrl #(.CLK_HZ(CLK_HZ), .LOCK_US(LOCK_US)) dut_i (
    .clk(clk), .rst_n(rst_n), .core_mode(core_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_rate(req_rate),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .pll_lock(pll_lock), .pll_err(pll_err), .done(done), .result(result)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Activity log, sampled away from the active edge.
  logic        log_sel  [0:63];
  logic [31:0] log_data [0:63];
  int          log_cyc  [0:63];
  int          nlog = 0;
  int          done_cnt = 0;
  int          done_cyc = 0;
  logic [1:0]  done_res = '0;

  always @(negedge clk) begin
    if (reg_wr_en && nlog < 64) begin
      log_sel[nlog]  <= reg_wr_sel;
      log_data[nlog] <= reg_wr_data;
      log_cyc[nlog]  <= cyc;
      nlog           <= nlog + 1;
    end
    if (done) begin
      done_cnt <= done_cnt + 1;
      done_cyc <= cyc;
      done_res <= result;
    end
  end

  // PLL model: loses lock on a control write, regains it after LOCK_DLY cycles.
  int lk_cnt = 0;
  always @(negedge clk) begin
    if (reg_wr_en && !reg_wr_sel) begin
      pll_lock <= 1'b0;
      lk_cnt   <= 0;
    end else if (!pll_lock && !lock_never) begin
      lk_cnt <= lk_cnt + 1;
      if (lk_cnt == LOCK_DLY) pll_lock <= 1'b1;
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wexp(input int i, input int f, input int o);
    return 32'((f << 9) | (i << 4) | (o << 2));
  endfunction

  task automatic send(input logic [11:0] r, input logic cm);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_rate  = r;
    core_mode = cm;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    int k = 0;
    while (done_cnt == d0 && k < 5000) begin
      @(negedge clk);
      k++;
    end
    @(negedge clk);
  endtask

  // Runs one request; returns log base index.
  task automatic run(input logic [11:0] r, input logic cm, output int b);
    int d0;
    b  = nlog;
    d0 = done_cnt;
    send(r, cm);
    wait_done(d0);
    check(done_cnt == d0 + 1, "R8 one done per request", done_cnt - d0, 1);
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(reg_wr_en == 1'b0, "R1 write after reset", reg_wr_en, 0);
  endtask

  task automatic t_raise_800;
    int b;
    run(12'd800, 1'b1, b);
    check(nlog - b == 2, "R5 write count 800", nlog - b, 2);
    check(log_sel[b] == 1'b1 && log_data[b] == 32'd1, "R5 divider up first", log_data[b], 1);
    check(log_sel[b+1] == 1'b0, "R5 ctrl second", log_sel[b+1], 0);
    check(log_cyc[b+1] == log_cyc[b] + 1, "R5 adjacent cycles", log_cyc[b+1] - log_cyc[b], 1);
    check(log_data[b+1] == wexp(0, 23, 1), "R3 word 800", log_data[b+1], wexp(0, 23, 1));
    check(done_cyc - log_cyc[b+1] == W + 1, "R4 relock wait", done_cyc - log_cyc[b+1], W + 1);
    check(done_res == 2'd0, "R7 ok 800", done_res, 0);
  endtask

  task automatic t_top_1600;
    int b;
    run(12'd1600, 1'b1, b);
    check(log_data[b+1] == wexp(1, 47, 0), "R3 word 1600", log_data[b+1], wexp(1, 47, 0));
    check(done_res == 2'd0, "R7 ok 1600", done_res, 0);
  endtask

  task automatic t_nearest;
    int b;
    run(12'd1590, 1'b0, b);
    check(log_data[b] == wexp(1, 47, 0), "R2 1590 to 1600", log_data[b], wexp(1, 47, 0));
    check(nlog - b == 1 && log_sel[b] == 1'b0, "R10 ctrl only", nlog - b, 1);
    run(12'd116, 1'b0, b);
    check(log_data[b] == wexp(0, 14, 3), "R2 116 to 125", log_data[b], wexp(0, 14, 3));
  endtask

  task automatic t_ties;
    int b;
    run(12'd1550, 1'b0, b);
    check(log_data[b] == wexp(1, 44, 0), "R2 tie 1550 to 1500", log_data[b], wexp(1, 44, 0));
    run(12'd450, 1'b1, b);
    check(nlog - b == 2, "R6 write count 450", nlog - b, 2);
    check(log_data[b] == wexp(1, 47, 2), "R2 tie 450 to 400", log_data[b], wexp(1, 47, 2));
    check(log_sel[b+1] == 1'b1 && log_data[b+1] == 32'd0, "R6 divider down", log_data[b+1], 0);
    check(log_cyc[b+1] == done_cyc, "R6 down with done", log_cyc[b+1], done_cyc);
  endtask

  task automatic t_limits;
    int b;
    run(12'd0, 1'b0, b);
    check(log_data[b] == wexp(0, 11, 3), "R2 floor to 100", log_data[b], wexp(0, 11, 3));
    run(12'd4095, 1'b0, b);
    check(log_data[b] == wexp(1, 47, 0), "R2 ceiling to 1600", log_data[b], wexp(1, 47, 0));
  endtask

  task automatic t_boundary_500;
    int b;
    run(12'd500, 1'b1, b);
    check(log_sel[b] == 1'b0, "R5 no raise at 500", log_sel[b], 0);
    check(log_data[b] == wexp(0, 14, 1), "R3 word 500", log_data[b], wexp(0, 14, 1));
    check(nlog - b == 2 && log_sel[b+1] == 1'b1 && log_data[b+1] == 32'd0, "R6 down at 500", nlog - b, 2);
    check(log_cyc[b+1] == done_cyc, "R6 down cycle 500", log_cyc[b+1], done_cyc);
  endtask

  task automatic t_timeout;
    int b;
    lock_never = 1'b1;
    run(12'd300, 1'b1, b);
    check(done_res == 2'd1, "R7 timeout", done_res, 1);
    check(nlog - b == 1, "R6 no down on timeout", nlog - b, 1);
    err_mode = 1'b1;
    run(12'd300, 1'b1, b);
    check(done_res == 2'd1, "R7 timeout over error", done_res, 1);
    lock_never = 1'b0;
    err_mode   = 1'b0;
  endtask

  task automatic t_error;
    int b;
    err_mode = 1'b1;
    run(12'd1200, 1'b1, b);
    check(done_res == 2'd2, "R7 error", done_res, 2);
    check(nlog - b == 2, "R6 no extra write on error", nlog - b, 2);
    run(12'd200, 1'b1, b);
    check(done_res == 2'd2 && nlog - b == 1, "R6 no down on error", nlog - b, 1);
    err_mode = 1'b0;
  endtask

  task automatic t_busy;
    int b;
    int d0;
    b  = nlog;
    d0 = done_cnt;
    send(12'd800, 1'b0);
    repeat (5) @(negedge clk);
    check(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
    req_rate  = 12'd200;
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_done(d0);
    repeat (60) @(negedge clk);
    check(done_cnt == d0 + 1, "R9 busy request dropped", done_cnt - d0, 1);
    check(nlog - b == 1 && log_data[b] == wexp(0, 23, 1), "R9 only first request written", nlog - b, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raise_800();
    t_top_1600();
    t_nearest();
    t_ties();
    t_limits();
    t_boundary_500();
    t_timeout();
    t_error();
    t_busy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule